// File: doc/BRIEF.md
# Serial Frequency Word Receiver

This block takes a frequency word delivered over a three-wire serial link (clock, data and a framing sync line) and places it in a 48-bit frequency register, aligned to the most significant end. The serial lines are asynchronous to the system clock. They pass through two-flop synchronizers, and the serial clock edge is detected in the system clock domain. The serial clock may run at up to one quarter of the system clock rate.

The word length, the position of the sync pulse, the sync polarity, the active serial clock edge and the bit order are set on static configuration inputs. A sync pulse can either announce a word one serial clock before its first bit, or close a word one serial clock after its last bit. When a word is complete, the block loads it into the top of the 48-bit output, clears the unused low bits and raises a valid strobe for one system clock. The consumer of the word is outside this block.

Top module: `sfw_rx`

## Requirements
- R1: While reset is asserted and directly after it, `freq_word` is zero and `word_valid` is low.
- R2: `cfg_len` sets the word size N: 3'b000 gives 8 bits, 3'b001 gives 16, 3'b010 gives 24, 3'b011 gives 32, and any value with bit 2 set gives 40. The word is loaded into `freq_word[47:48-N]` and bits `[47-N:0]` are cleared.
- R3: With `cfg_sync_early`=1, an active sync on one active serial clock edge starts a word, and the next N active edges carry its N data bits.
- R4: With `cfg_sync_early`=0, data is shifted on every active edge that carries no sync. An active sync on the edge after the last bit commits the most recent N bits as the word.
- R5: `cfg_sync_low`=1 makes sync active low, and 0 makes it active high.
- R6: `cfg_fall_edge`=0 samples data and sync on rising serial clock edges, and 1 samples them on falling edges.
- R7: `cfg_lsb_first`=0 means the most significant bit of the word arrives first, and 1 means the least significant bit arrives first.
- R8: In sync-early mode, a sync that arrives before a word is complete discards the partial word and restarts the bit count. This also holds when the sync lands on the edge that would have carried the final bit. No word is loaded in that case.
- R9: Each completed word produces exactly one `word_valid` pulse, one system clock long. `freq_word` keeps its value between loads, and serial edges outside a frame change nothing.
- R10: The data line is ignored on an edge that carries an active sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len | input | 3 | Word length select |
| cfg_sync_early | input | 1 | 1: sync precedes the word, 0: sync follows it |
| cfg_sync_low | input | 1 | 1: sync active low |
| cfg_fall_edge | input | 1 | 1: sample on falling serial clock edge |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_sync | input | 1 | Serial framing sync, asynchronous |
| freq_word | output | 48 | Received word, aligned to the top |
| word_valid | output | 1 | One-cycle strobe when a new word is loaded |

## Verification
In sync-early mode, the completion of a word and a restart can fall on the same serial edge. This happens when a sync arrives exactly where the final data bit was due. The bench provokes this by sending one bit short of a word, raising sync with the data line high on the next edge, and then sending a full word. It passes only if a single valid pulse appears and the loaded value is the second word, with no trace of the discarded bits or of the data bit on the sync edge.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

  localparam int unsigned LEN_STEP = 8;

  typedef struct packed {
    logic [2:0] len;
    logic       early;
    logic       sync_low;
    logic       fall;
    logic       lsb_first;
  } sfw_cfg_t;

  function automatic int unsigned word_bits(logic [2:0] len);
    if (len[2]) return 5 * LEN_STEP;
    return (int'(len) + 1) * LEN_STEP;
  endfunction

endpackage

// File: rtl/sfw_sync.sv
module sfw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= '0;
          else        stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sfw_edge.sv
module sfw_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic fall,
  output logic strobe
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sclk_s;
  end

  always_comb begin
    if (fall) strobe = prev_q & ~sclk_s;
    else      strobe = ~prev_q & sclk_s;
  end

  // R6: a legal serial clock never gives two strobes in a row
  p_strobe_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

endmodule

// File: rtl/sfw_core.sv
module sfw_core
  import sfw_pkg::*;
#(
  parameter int FW = 48,
  parameter int SW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sfw_cfg_t      cfg,
  input  logic          strobe,
  input  logic          bit_in,
  input  logic          sync_raw,
  output logic [FW-1:0] freq_word,
  output logic          word_valid
);

  localparam int CW  = $clog2(SW + 1);
  localparam int PAD = FW - SW;

  logic [SW-1:0] sh_q, sh_d, shifted, src;
  logic [CW-1:0] cnt_q, cnt_d, nb;
  logic          act_q, act_d, load, sync_act;
  logic [FW-1:0] freq_q, freq_d;
  logic          valid_q;

  function automatic logic [FW-1:0] align_word(logic [SW-1:0] s, logic [CW-1:0] n,
                                               logic lsbf);
    logic [FW-1:0] wide;
    wide = {s, {PAD{1'b0}}};
    if (lsbf) return wide & ~({FW{1'b1}} >> n);
    return wide << (CW'(SW) - n);
  endfunction

  always_comb begin
    sync_act = sync_raw ^ cfg.sync_low;
    nb       = CW'(word_bits(cfg.len));
    if (cfg.lsb_first) shifted = {bit_in, sh_q[SW-1:1]};
    else               shifted = {sh_q[SW-2:0], bit_in};
    src = cfg.early ? shifted : sh_q;
  end

  // next-state
  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    act_d = act_q;
    load  = 1'b0;
    if (strobe) begin
      if (cfg.early) begin
        if (sync_act) begin
          act_d = 1'b1;
          cnt_d = '0;
          sh_d  = '0;
        end else if (act_q) begin
          sh_d = shifted;
          if (cnt_q == nb - CW'(1)) begin
            load  = 1'b1;
            act_d = 1'b0;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
      end else begin
        act_d = 1'b0;
        cnt_d = '0;
        if (sync_act) load = 1'b1;
        else          sh_d = shifted;
      end
    end
    freq_d = load ? align_word(src, nb, cfg.lsb_first) : freq_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      act_q   <= 1'b0;
      freq_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (strobe) begin
        sh_q  <= sh_d;
        cnt_q <= cnt_d;
        act_q <= act_d;
      end
      if (load) freq_q <= freq_d;
      valid_q <= load;
    end
  end

  assign freq_word  = freq_q;
  assign word_valid = valid_q;

  // R3: the bit count stays inside the selected word length
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q < nb));

  // R2: unused low bits are clear whenever a word is presented
  p_low_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> ((freq_word & ({FW{1'b1}} >> nb)) == '0));

  // R9: valid is a single-cycle pulse
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  // R9: output holds unless a load is signalled
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(freq_word));

  // R8: an early-mode sync edge never completes a word
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && cfg.early && sync_act) |=> !word_valid);

endmodule

// File: rtl/sfw_rx.sv
module sfw_rx
  import sfw_pkg::*;
#(
  parameter int FREQ_W      = 48,
  parameter int SHIFT_W     = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_len,
  input  logic              cfg_sync_early,
  input  logic              cfg_sync_low,
  input  logic              cfg_fall_edge,
  input  logic              cfg_lsb_first,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_sync,
  output logic [FREQ_W-1:0] freq_word,
  output logic              word_valid
);

  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  sfw_cfg_t cfg;
  assign cfg = '{len: cfg_len, early: cfg_sync_early, sync_low: cfg_sync_low,
                 fall: cfg_fall_edge, lsb_first: cfg_lsb_first};

  logic [2:0] ser_s;
  logic       strobe;

  sfw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({ser_sync, ser_data, ser_clk}),
    .q     (ser_s)
  );

  sfw_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .sclk_s (ser_s[0]),
    .fall   (cfg.fall),
    .strobe (strobe)
  );

  sfw_core #(.FW(FREQ_W), .SW(SHIFT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cfg        (cfg),
    .strobe     (strobe),
    .bit_in     (ser_s[1]),
    .sync_raw   (ser_s[2]),
    .freq_word  (freq_word),
    .word_valid (word_valid)
  );

endmodule

// File: tb/sfw_rx_test.sv
module sfw_rx_test;

  localparam int CLK_NS = 10;
  localparam int HALF   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_len = 3'd0;
  logic        cfg_sync_early = 1'b1, cfg_sync_low = 1'b0;
  logic        cfg_fall_edge = 1'b0, cfg_lsb_first = 1'b0;
  logic        ser_clk = 1'b0, ser_data = 1'b0, ser_sync = 1'b0;
  logic [47:0] freq_word;
  logic        word_valid;

  int n_run = 0, n_fail = 0;
  int vcnt = 0, vrun = 0, vmax = 0;

  always #(CLK_NS/2) clk = ~clk;

  sfw_rx uut (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_sync_early(cfg_sync_early),
    .cfg_sync_low(cfg_sync_low), .cfg_fall_edge(cfg_fall_edge),
    .cfg_lsb_first(cfg_lsb_first), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_sync(ser_sync), .freq_word(freq_word), .word_valid(word_valid)
  );

  always @(negedge clk) begin
    if (word_valid) begin
      vcnt++;
      vrun++;
      if (vrun > vmax) vmax = vrun;
    end else begin
      vrun = 0;
    end
  end

  // {len, early, sync_low, fall, lsb_first, data (right aligned), expected}
  localparam logic [94:0] VEC [6] = '{
    {3'b000, 4'b1000, 40'h00000000A5, 48'hA50000000000},
    {3'b001, 4'b0101, 40'h0000001234, 48'h123400000000},
    {3'b010, 4'b1110, 40'h0000C0FFEE, 48'hC0FFEE000000},
    {3'b011, 4'b0011, 40'h00DEADBEEF, 48'hDEADBEEF0000},
    {3'b100, 4'b1011, 40'h0123456789, 48'h012345678900},
    {3'b111, 4'b0100, 40'h9876543210, 48'h987654321000}
  };

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [2:0] len, input logic e, input logic l,
                          input logic f, input logic b);
    cfg_len = len; cfg_sync_early = e; cfg_sync_low = l;
    cfg_fall_edge = f; cfg_lsb_first = b;
    repeat (2) @(negedge clk);
    ser_clk = f; ser_sync = l; ser_data = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // one serial clock period with an active edge in the middle
  task automatic edge_(input logic d, input logic s);
    ser_data = d;
    ser_sync = s ^ cfg_sync_low;
    repeat (HALF) @(negedge clk);
    ser_clk = ~cfg_fall_edge;
    repeat (HALF) @(negedge clk);
    ser_clk = cfg_fall_edge;
  endtask

  task automatic bits(input int n, input logic [39:0] data, input logic lsbf);
    for (int i = 0; i < n; i++) edge_(lsbf ? data[i] : data[n-1-i], 1'b0);
  endtask

  task automatic send(input int n, input logic [39:0] data);
    if (cfg_sync_early) edge_(1'b0, 1'b1);
    bits(n, data, cfg_lsb_first);
    if (!cfg_sync_early) edge_(1'b0, 1'b1);
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int v0;
    logic [47:0] held;
    // R1: reset state
    repeat (5) @(negedge clk);
    check("R1 freq_word in reset", freq_word, 48'h0);
    check("R1 word_valid in reset", {47'h0, word_valid}, 48'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 freq_word after reset", freq_word, 48'h0);

    // vector walk: R2 lengths, R3/R4 sync position, R5 polarity,
    // R6 edge, R7 bit order
    for (int k = 0; k < 6; k++) begin
      logic [94:0] v;
      int n;
      v = VEC[k];
      set_mode(v[94:92], v[91], v[90], v[89], v[88]);
      n = v[94] ? 40 : (int'(v[93:92]) + 1) * 8;
      v0 = vcnt;
      send(n, v[87:48]);
      check($sformatf("R2 word %0d (R3 R4 R5 R6 R7 modes)", k), freq_word, v[47:0]);
      check($sformatf("R9 one valid for word %0d", k), 48'(vcnt - v0), 48'd1);
    end

    // R8: mid-word sync restarts the count
    set_mode(3'b001, 1'b1, 1'b0, 1'b0, 1'b0);
    v0 = vcnt;
    edge_(1'b0, 1'b1);
    bits(5, 40'h1F, 1'b0);
    send(16, 40'hBEEF);
    check("R8 restart keeps second word", freq_word, 48'hBEEF00000000);
    check("R8 restart one valid", 48'(vcnt - v0), 48'd1);

    // R8 + R10: sync where the final bit was due, data high on that edge
    set_mode(3'b000, 1'b1, 1'b0, 1'b0, 1'b0);
    v0 = vcnt;
    edge_(1'b0, 1'b1);
    bits(7, 40'h7F, 1'b0);
    edge_(1'b1, 1'b1);
    bits(8, 40'h3C, 1'b0);
    repeat (12) @(negedge clk);
    check("R8 collision word", freq_word, 48'h3C0000000000);
    check("R8 collision one valid", 48'(vcnt - v0), 48'd1);

    // R10: late mode, data high on the committing sync edge is not shifted
    set_mode(3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
    v0 = vcnt;
    bits(8, 40'h81, 1'b0);
    edge_(1'b1, 1'b1);
    repeat (12) @(negedge clk);
    check("R10 sync edge data ignored", freq_word, 48'h810000000000);

    // R4: late mode keeps the most recent N bits
    bits(12, 40'hF5A, 1'b0);
    edge_(1'b0, 1'b1);
    repeat (12) @(negedge clk);
    check("R4 most recent bits", freq_word, 48'h5A0000000000);
    check("R4 two valids", 48'(vcnt - v0), 48'd2);

    // R9: edges outside a frame change nothing
    set_mode(3'b000, 1'b1, 1'b0, 1'b0, 1'b0);
    held = freq_word;
    v0 = vcnt;
    bits(10, 40'h3FF, 1'b0);
    repeat (12) @(negedge clk);
    check("R9 output held", freq_word, held);
    check("R9 no valid outside frame", 48'(vcnt - v0), 48'd0);
    check("R9 valid width", 48'(vmax), 48'd1);

    // R5: an edge with sync at its inactive level does not start a word
    set_mode(3'b000, 1'b1, 1'b1, 1'b0, 1'b0);
    v0 = vcnt;
    bits(9, 40'h0AA, 1'b0);
    repeat (12) @(negedge clk);
    check("R5 inactive sync level ignored", 48'(vcnt - v0), 48'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule